// File: doc/BRIEF.md
# UART Receive Queue Controller

This block sits between a serial receiver's byte buffer and a RAM. It moves each received byte into a RAM ring or linear buffer without any CPU work. An 8-bit control register governs it. Some of its bits are owned by the CPU and some by the queue engine, and a few are shared, each with its own set and clear rules. The CPU programs a start address and a byte count, sets the queue enable bit, and then sets the start bit. From then on, every received byte becomes one RAM write request. The address rises by a programmable step and the remaining count falls by one.

The receive interrupt flag can be raised in three ways: for every byte, when a byte equals a match value, or when the count runs out. With overflow enable set, the transfer keeps running past the end of the buffer. With auto-reload also set, the address and count return to their start values, which forms a circular buffer. When the queue is disabled, bytes bypass the RAM path and land in a directly readable data register. A byte that arrives while the queue is enabled but stopped is flagged as an overrun.

Top module: `rxq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, `ram_we` and `rx_irq` are 0, and the address and count are 0. The control bit layout, from bit 7 to bit 0, is: queue enable, match enable, per-byte interrupt enable, overflow enable, overrun flag, auto-reload, halt, run.
- R2: While queue enable (bit 7) is 0, a received byte causes no RAM write, does not set the overrun flag, and is captured in `direct_data`.
- R3: A CPU write can set run (bit 0) only if queue enable was already 1 before the write. A CPU write that takes run from 0 to 1 loads the current address from `start_addr` and the count from `start_cnt`. A `start_cnt` of 0 stands for 2^CNT_W bytes.
- R4: A byte that arrives while queue enable and run are 1 and halt is 0 produces exactly one RAM write in the next cycle. That write carries the current address and the byte. In the same cycle, the address grows by ADDR_STEP and the count drops by 1.
- R5: With match enable (bit 6) set, an accepted byte equal to `match_val` raises `rx_irq`. With match enable clear, it does not.
- R6: With per-byte interrupt enable (bit 5) set, every accepted byte raises `rx_irq`.
- R7: When an accepted byte brings the count to 0 and overflow enable (bit 4) is 0, the engine clears run and raises `rx_irq`.
- R8: With overflow enable set, reaching a count of 0 still raises `rx_irq`, but run stays set. If auto-reload (bit 2) is also set, the address and count return to `start_addr` and `start_cnt` in that same cycle.
- R9: The engine sets the overrun flag (bit 3) when a byte arrives while queue enable is 1 and run is 0. The CPU can only clear this flag: writing 0 clears it and writing 1 leaves it unchanged.
- R10: While halt (bit 1) is set, arriving bytes are dropped, with no RAM write and no change to address or count. After halt is cleared, transfers resume at the held address and count, with no reload.
- R11: `rx_irq` stays set until `irq_clr` is pulsed. A new interrupt cause in the same cycle as `irq_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte was received |
| rx_data | input | DATA_W | Received byte |
| cpu_wr | input | 1 | CPU write strobe for the control register |
| cpu_wdata | input | 8 | CPU write data for the control register |
| irq_clr | input | 1 | Clears the receive interrupt flag |
| match_val | input | DATA_W | Value compared against accepted bytes |
| start_addr | input | ADDR_W | Programmed buffer start address |
| start_cnt | input | CNT_W | Programmed buffer length in bytes |
| ram_we | output | 1 | RAM write request |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| rx_irq | output | 1 | Receive interrupt flag |
| ctrl_rd | output | 8 | Control register readback |
| cur_addr | output | ADDR_W | Next RAM write address |
| cur_cnt | output | CNT_W | Bytes remaining before the terminal count |
| direct_data | output | DATA_W | Last byte received while the queue was disabled |

## Verification
The bench builds the controller with an 8-bit address and a 3-bit count, with the buffer starting at 0x40 and three bytes long. With a buffer this short, terminal count, run clear, auto-reload wrap-around and a second terminal count are all reached within a few dozen cycles. The byte width stays at 8 and the address step at 1, so every address the bench expects follows from simple counting. The match register is fixed at 0xA5 so that both matching and non-matching bytes appear in the stream.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // Control register image, bit 7 first.
   typedef struct packed {
      logic qen;   // queue enable
      logic men;   // match enable
      logic bie;   // per-byte interrupt enable
      logic ove;   // overflow enable
      logic ovf;   // overrun flag
      logic arl;   // auto-reload
      logic hlt;   // halt
      logic run;   // transfer active
   } rxq_ctrl_t;

   typedef enum logic [2:0] {
      RXQ_EV_NONE,
      RXQ_EV_BYPASS,
      RXQ_EV_ORPHAN,
      RXQ_EV_HELD,
      RXQ_EV_TAKE
   } rxq_ev_e;

   function automatic rxq_ev_e rxq_classify(input logic valid, input rxq_ctrl_t c);
      if (!valid)      return RXQ_EV_NONE;
      else if (!c.qen) return RXQ_EV_BYPASS;
      else if (!c.run) return RXQ_EV_ORPHAN;
      else if (c.hlt)  return RXQ_EV_HELD;
      else             return RXQ_EV_TAKE;
   endfunction

endpackage

// File: rtl/rxq_ctlreg.sv
module rxq_ctlreg
   import rxq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_wr,
   input  logic [7:0] cpu_wdata,
   input  logic       eng_ovf_set,
   input  logic       eng_run_clr,
   output rxq_ctrl_t  ctrl_q,
   output logic       run_start
);

   rxq_ctrl_t wv;
   rxq_ctrl_t nxt;

   assign wv = rxq_ctrl_t'(cpu_wdata);

   always_comb begin
      nxt       = ctrl_q;
      run_start = 1'b0;
      if (cpu_wr) begin
         nxt.qen   = wv.qen;
         nxt.men   = wv.men;
         nxt.bie   = wv.bie;
         nxt.ove   = wv.ove;
         nxt.arl   = wv.arl;
         nxt.hlt   = wv.hlt;
         // CPU may only clear the overrun flag
         nxt.ovf   = ctrl_q.ovf & wv.ovf;
         // run may only be raised once the queue is already enabled
         nxt.run   = wv.run & ctrl_q.qen;
         run_start = wv.run & ctrl_q.qen & ~ctrl_q.run;
      end
      // engine actions take precedence over a simultaneous CPU write
      if (eng_ovf_set) nxt.ovf = 1'b1;
      if (eng_run_clr) nxt.run = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= nxt;
   end

endmodule

// File: rtl/rxq_xfer.sv
module rxq_xfer #(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_STEP = 1,
   parameter bit RAM_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic              arl,
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_cnt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              last,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata
);

   localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
   localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(ADDR_STEP);

   assign last = take && (cnt_q == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         addr_q <= start_addr;
         cnt_q  <= start_cnt;
      end else if (take) begin
         if (last && arl) begin
            addr_q <= start_addr;
            cnt_q  <= start_cnt;
         end else begin
            addr_q <= addr_q + STEP;
            cnt_q  <= cnt_q - CNT_ONE;
         end
      end
   end

   if (RAM_REG) begin : g_ram_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
         end else begin
            ram_we <= take;
            if (take) begin
               ram_addr  <= addr_q;
               ram_wdata <= data;
            end
         end
      end
   end else begin : g_ram_comb
      assign ram_we    = take;
      assign ram_addr  = addr_q;
      assign ram_wdata = data;
   end

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
   parameter int DATA_W   = 8,
   parameter bit MATCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] match_val,
   input  logic              men,
   input  logic              bie,
   input  logic              last,
   input  logic              irq_clr,
   output logic              irq_q
);

   logic hit;
   logic raise;

   if (MATCH_EN) begin : g_match
      assign hit = take && men && (data == match_val);
   end else begin : g_nomatch
      assign hit = 1'b0;
   end

   assign raise = (take && bie) || hit || last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (raise)   irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int ADDR_STEP = 1,
   parameter bit MATCH_EN  = 1'b1,
   parameter bit RAM_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   input  logic              irq_clr,
   input  logic [DATA_W-1:0] match_val,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_cnt,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              rx_irq,
   output logic [7:0]        ctrl_rd,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic [DATA_W-1:0] direct_data
);

   if (DATA_W < 1)    begin : g_bad_data $error("rxq_ctrl: DATA_W must be positive"); end
   if (ADDR_W < 2)    begin : g_bad_addr $error("rxq_ctrl: ADDR_W must be at least 2"); end
   if (CNT_W < 1)     begin : g_bad_cnt  $error("rxq_ctrl: CNT_W must be positive"); end
   if (ADDR_STEP < 1) begin : g_bad_step $error("rxq_ctrl: ADDR_STEP must be positive"); end

   rxq_ctrl_t ctrl;
   rxq_ev_e   ev;
   logic      take;
   logic      run_start;
   logic      last;

   assign ev      = rxq_classify(rx_valid, ctrl);
   assign take    = (ev == RXQ_EV_TAKE);
   assign ctrl_rd = ctrl;

   rxq_ctlreg u_ctlreg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_wr      (cpu_wr),
      .cpu_wdata   (cpu_wdata),
      .eng_ovf_set (ev == RXQ_EV_ORPHAN),
      .eng_run_clr (last && !ctrl.ove),
      .ctrl_q      (ctrl),
      .run_start   (run_start)
   );

   rxq_xfer #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W),
      .ADDR_STEP (ADDR_STEP),
      .RAM_REG   (RAM_REG)
   ) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (run_start),
      .take       (take),
      .arl        (ctrl.arl),
      .data       (rx_data),
      .start_addr (start_addr),
      .start_cnt  (start_cnt),
      .addr_q     (cur_addr),
      .cnt_q      (cur_cnt),
      .last       (last),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata)
   );

   rxq_irq #(
      .DATA_W   (DATA_W),
      .MATCH_EN (MATCH_EN)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .data      (rx_data),
      .match_val (match_val),
      .men       (ctrl.men),
      .bie       (ctrl.bie),
      .last      (last),
      .irq_clr   (irq_clr),
      .irq_q     (rx_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     direct_data <= '0;
      else if (ev == RXQ_EV_BYPASS)   direct_data <= rx_data;
   end

endmodule

// File: rtl/rxq_ctrl_chk.sv
module rxq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       cpu_wr,
   input logic       irq_clr,
   input logic       ram_we,
   input logic       rx_irq,
   input logic [7:0] ctrl_rd
);

   AST_RUN_NEEDS_QEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_rd[0]) |-> $past(ctrl_rd[7])); // R3

   AST_BYPASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl_rd[7]) |-> !ram_we); // R2

   AST_WRITE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(rx_valid && ctrl_rd[0] && !ctrl_rd[1])); // R4

   AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_rd[3]) |-> $past(rx_valid && ctrl_rd[7] && !ctrl_rd[0])); // R9

   AST_OVE_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd[0] && ctrl_rd[4] && !cpu_wr) |=> ctrl_rd[0]); // R8

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !irq_clr) |=> rx_irq); // R11

endmodule

bind rxq_ctrl rxq_ctrl_chk u_rxq_ctrl_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_valid (rx_valid),
   .cpu_wr   (cpu_wr),
   .irq_clr  (irq_clr),
   .ram_we   (ram_we),
   .rx_irq   (rx_irq),
   .ctrl_rd  (ctrl_rd)
);

// File: tb/rxq_ctrl_test.sv
module rxq_ctrl_test;

   localparam int DW = 8;
   localparam int AW = 8;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx_valid;
   logic [DW-1:0] rx_data;
   logic          cpu_wr;
   logic [7:0]    cpu_wdata;
   logic          irq_clr;
   logic [DW-1:0] match_val;
   logic [AW-1:0] start_addr;
   logic [CW-1:0] start_cnt;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic          rx_irq;
   logic [7:0]    ctrl_rd;
   logic [AW-1:0] cur_addr;
   logic [CW-1:0] cur_cnt;
   logic [DW-1:0] direct_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rxq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .irq_clr(irq_clr),
      .match_val(match_val), .start_addr(start_addr), .start_cnt(start_cnt),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .rx_irq(rx_irq), .ctrl_rd(ctrl_rd), .cur_addr(cur_addr),
      .cur_cnt(cur_cnt), .direct_data(direct_data)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] wd;
      logic       rv;
      logic [7:0] rd;
      logic       clr;
      logic       e_we;
      logic [7:0] e_addr;
      logic       e_irq;
      logic [7:0] e_ctrl;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 31;
   // wr wd rv rd clr | we addr irq ctrl | requirement
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h88, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80, 4'd9 },  // R9 CPU cannot set overrun
      '{1'b1, 8'h81, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h81, 4'd3 },  // R3 start, load 0x40/3
      '{1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b1, 8'h40, 1'b0, 8'h81, 4'd4 },  // R4
      '{1'b0, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b1, 8'h41, 1'b0, 8'h81, 4'd5 },  // R5 match off
      '{1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 1'b1, 8'h42, 1'b1, 8'h80, 4'd7 },  // R7 terminal
      '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h80, 4'd11},  // R11 clear
      '{1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0, 8'h88, 4'd9 },  // R9 overrun
      '{1'b1, 8'h88, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h88, 4'd9 },  // R9 write 1 keeps
      '{1'b1, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h80, 4'd9 },  // R9 write 0 clears
      '{1'b1, 8'hC1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hC1, 4'd3 },  // R3 restart
      '{1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b1, 8'h40, 1'b0, 8'hC1, 4'd5 },  // R5 no match
      '{1'b0, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b1, 8'h41, 1'b1, 8'hC1, 4'd5 },  // R5 match
      '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'hC1, 4'd11},  // R11
      '{1'b1, 8'hC3, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hC3, 4'd10},  // R10 halt
      '{1'b0, 8'h00, 1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 8'hC3, 4'd10},  // R10 dropped
      '{1'b1, 8'hC1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hC1, 4'd10},  // R10 resume
      '{1'b0, 8'h00, 1'b1, 8'h66, 1'b0, 1'b1, 8'h42, 1'b1, 8'hC0, 4'd10},  // R10 held address
      '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'hC0, 4'd11},  // R11
      '{1'b1, 8'h95, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h95, 4'd8 },  // R8 circular
      '{1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b1, 8'h40, 1'b0, 8'h95, 4'd8 },  // R8
      '{1'b0, 8'h00, 1'b1, 8'h02, 1'b0, 1'b1, 8'h41, 1'b0, 8'h95, 4'd8 },  // R8
      '{1'b0, 8'h00, 1'b1, 8'h03, 1'b0, 1'b1, 8'h42, 1'b1, 8'h95, 4'd8 },  // R8 run kept
      '{1'b0, 8'h00, 1'b1, 8'h04, 1'b0, 1'b1, 8'h40, 1'b1, 8'h95, 4'd8 },  // R8 wrapped
      '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h95, 4'd11},  // R11
      '{1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hA1, 4'd6 },  // R6
      '{1'b0, 8'h00, 1'b1, 8'h07, 1'b0, 1'b1, 8'h41, 1'b1, 8'hA1, 4'd6 },  // R6 per byte
      '{1'b0, 8'h00, 1'b1, 8'h08, 1'b1, 1'b1, 8'h42, 1'b1, 8'hA0, 4'd11},  // R11 set wins, R7
      '{1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 4'd2 },  // R2 disable
      '{1'b0, 8'h00, 1'b1, 8'h77, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 4'd2 },  // R2 bypass
      '{1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 4'd3 },  // R3 run refused
      '{1'b0, 8'h00, 1'b1, 8'h78, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 4'd2 }   // R2 bypass
   };

   task automatic chk(input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n      = 1'b0;
      rx_valid   = 1'b0;
      rx_data    = '0;
      cpu_wr     = 1'b0;
      cpu_wdata  = '0;
      irq_clr    = 1'b0;
      match_val  = 8'hA5;
      start_addr = 8'h40;
      start_cnt  = 3'd3;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(1, "ctrl after reset", 32'(ctrl_rd), 32'h00);
      chk(1, "ram_we after reset", 32'(ram_we), 32'h0);
      chk(1, "irq after reset", 32'(rx_irq), 32'h0);
      chk(1, "count after reset", 32'(cur_cnt), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cpu_wr    = VEC[i].wr;
         cpu_wdata = VEC[i].wd;
         rx_valid  = VEC[i].rv;
         rx_data   = VEC[i].rd;
         irq_clr   = VEC[i].clr;
         @(negedge clk);
         chk(int'(VEC[i].req), $sformatf("step %0d ram_we", i), 32'(ram_we), 32'(VEC[i].e_we));
         if (VEC[i].e_we)
            chk(int'(VEC[i].req), $sformatf("step %0d ram_addr", i), 32'(ram_addr), 32'(VEC[i].e_addr));
         if (VEC[i].e_we)
            chk(int'(VEC[i].req), $sformatf("step %0d ram_wdata", i), 32'(ram_wdata), 32'(VEC[i].rd));
         chk(int'(VEC[i].req), $sformatf("step %0d rx_irq", i), 32'(rx_irq), 32'(VEC[i].e_irq));
         chk(int'(VEC[i].req), $sformatf("step %0d ctrl", i), 32'(ctrl_rd), 32'(VEC[i].e_ctrl));
      end
      cpu_wr   = 1'b0;
      rx_valid = 1'b0;
      irq_clr  = 1'b0;

      // R2 bypassed byte is readable directly
      chk(2, "direct_data", 32'(direct_data), 32'h78);
      // R4 address and count after the last accepted byte (0x42 -> 0x43, 1 -> 0)
      chk(4, "cur_addr", 32'(cur_addr), 32'h43);
      chk(4, "cur_cnt", 32'(cur_cnt), 32'h0);

      // R1 reset in the middle of operation
      cpu_wr    = 1'b1;
      cpu_wdata = 8'hB5;
      @(negedge clk);
      cpu_wr = 1'b0;
      rst_n  = 1'b0;
      @(negedge clk);
      chk(1, "ctrl after second reset", 32'(ctrl_rd), 32'h00);
      chk(1, "irq after second reset", 32'(rx_irq), 32'h0);
      chk(1, "addr after second reset", 32'(cur_addr), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule